// File: doc/BRIEF.md
# Waveform Timer with Single Compare Channel

An 8-bit counter that advances on a qualified tick and compares itself against one stored value, driving a single output pin from that comparison. A 2-bit mode selects how the counter runs and where its top lies: free-running, clear-on-compare (CTC), fast PWM (single slope), or phase-correct PWM (up then down). A second 2-bit field decides what the compare event does to the waveform: toggle, clear or set it, or in the PWM modes produce a non-inverted or inverted pulse train.

The compare value is written into a buffer. It reaches the comparator at once in the non-PWM modes, and only at a period boundary in the PWM modes, so a PWM waveform never shows a glitch. Two sticky flags report overflow and compare events, and software clears them by writing ones. The pin carries the waveform only when the output field is active and the pin-direction enable is high. Otherwise the port data passes straight through.

Top module: `wave_timer`

## Requirements
- R1: The counter changes only on clock edges where `tickEn` is high. Mode 0 (free-running) counts up and wraps from 0xFF to 0x00.
- R2: In mode 2 (CTC), a tick taken while the count equals the active compare value loads 0 into the counter. Every other tick increments it.
- R3: In mode 1 (phase-correct), the count rises to 0xFF and then falls to 0x00. A tick at 0xFF while rising gives 0xFE and turns the direction down. A tick at 0x00 while falling gives 0x01 and turns it up.
- R4: Writing the compare buffer (address 1) updates the active compare value on the same edge in modes 0 and 2. In modes 1 and 3 the buffer moves to the active value only on a tick taken at count 0xFF.
- R5: The overflow flag is set by a tick at count 0xFF in modes 0, 2 and 3, and by a tick at count 0x00 in mode 1. Writing address 2 with bit 0 set clears it, and a same-cycle set wins.
- R6: The compare flag is set by a tick at which the count equals the active compare value. Writing address 2 with bit 1 set clears it, and a same-cycle set wins.
- R7: In modes 0 and 2, on a compare tick, output field 01 toggles the waveform, 10 clears it and 11 sets it.
- R8: In mode 3 (fast PWM), field 10 clears the waveform on a compare tick and sets it on the tick at 0xFF, so it is high from count 0 onward. Field 11 does the inverse.
- R9: In mode 3, when the active compare value is 0xFF and field bit 1 is set, the compare tick does not change the waveform. The 0xFF-tick set or clear still applies.
- R10: In mode 1, field 10 clears the waveform on a compare tick while rising and sets it on a compare tick while falling. Field 11 does the inverse.
- R11: `pinOut` equals the waveform when the output field is nonzero, `pinDirEn` is high, and the case of field 01 in modes 1 or 3 does not apply. In every other case it equals `portDataIn`.
- R12: Address 0 holds the control register: bits 1:0 are the mode and bits 3:2 are the output field. A synchronous reset clears the counter, the direction, the compare buffer and active value, both flags, the waveform and the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Count-enable tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 control, 1 compare buffer, 2 flag clear) |
| wrData | input | 8 | Register write data |
| pinDirEn | input | 1 | Pin-direction enable; must be high for the waveform to reach the pin |
| portDataIn | input | 1 | Port data shown on the pin when the waveform is disconnected |
| pinOut | output | 1 | Pin value |
| count | output | 8 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare flag |

## Verification
The assertions check local rules on every cycle. The count holds between ticks, CTC returns to zero after a compare tick, phase-correct turns around at the top, the flags stay set until cleared, and the fast-PWM compare is suppressed when the compare value is 0xFF. Some behaviour only the bench scenarios can show: full waveform shapes over whole periods, compare values deferred to the period boundary in the PWM modes, the inverted outputs, and the pin multiplexing across every mode and field combination. The bench shows these by comparing every cycle against an independent model.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PHASE = 2'd1,
    MODE_CTC   = 2'd2,
    MODE_FAST  = 2'd3
  } waveMode_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef struct packed {
    logic cntInc;
    logic cntDec;
    logic cntClr;
    logic dirToDown;
    logic dirToUp;
    logic waveSet;
    logic waveClr;
    logic waveTgl;
    logic loadCmp;
    logic cmpDirect;
    logic ovfSet;
    logic cmpSet;
  } strobe_t;
endpackage

// File: rtl/wave_timer_ctrl.sv
module wave_timer_ctrl
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              pinDirEn,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic              cntDown,
  output strobe_t           stb,
  output logic              pinConnect
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  waveMode_t  modeReg;
  logic [1:0] outModeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg    <= MODE_FREE;
      outModeReg <= 2'b00;
    end else if (wrEn && wrAddr == ADDR_W'(ADDR_CTRL)) begin
      modeReg    <= waveMode_t'(wrData[1:0]);
      outModeReg <= wrData[3:2];
    end
  end

  logic atMax, atMin, isMatch, isPwm;
  assign atMax   = (cnt == CNT_MAX);
  assign atMin   = (cnt == CNT_MIN);
  assign isMatch = (cnt == cmpVal);
  assign isPwm   = (modeReg == MODE_PHASE) || (modeReg == MODE_FAST);

  always_comb begin
    stb = '0;
    stb.cmpDirect = (modeReg == MODE_FREE) || (modeReg == MODE_CTC);
    if (tickEn) begin
      stb.cmpSet = isMatch;
      unique case (modeReg)
        MODE_FREE, MODE_CTC: begin
          if (modeReg == MODE_CTC && isMatch) stb.cntClr = 1'b1;
          else stb.cntInc = 1'b1;
          stb.ovfSet = atMax;
          if (isMatch) begin
            stb.waveTgl = (outModeReg == 2'b01);
            stb.waveClr = (outModeReg == 2'b10);
            stb.waveSet = (outModeReg == 2'b11);
          end
        end
        MODE_FAST: begin
          stb.cntInc  = 1'b1;
          stb.ovfSet  = atMax;
          stb.loadCmp = atMax;
          if (outModeReg[1]) begin
            if (isMatch && cmpVal != CNT_MAX) begin
              stb.waveSet = outModeReg[0];
              stb.waveClr = ~outModeReg[0];
            end
            if (atMax) begin
              stb.waveSet = ~outModeReg[0];
              stb.waveClr = outModeReg[0];
            end
          end
        end
        MODE_PHASE: begin
          stb.ovfSet  = atMin;
          stb.loadCmp = atMax;
          if (cntDown) begin
            if (atMin) begin
              stb.cntInc  = 1'b1;
              stb.dirToUp = 1'b1;
            end else stb.cntDec = 1'b1;
          end else begin
            if (atMax) begin
              stb.cntDec    = 1'b1;
              stb.dirToDown = 1'b1;
            end else stb.cntInc = 1'b1;
          end
          if (outModeReg[1] && isMatch) begin
            stb.waveSet = cntDown ^ outModeReg[0];
            stb.waveClr = ~(cntDown ^ outModeReg[0]);
          end
        end
        default: ;
      endcase
    end
  end

  assign pinConnect = pinDirEn && (outModeReg != 2'b00) &&
                      !(isPwm && outModeReg == 2'b01);

  p_ctc_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (modeReg == MODE_CTC && tickEn && isMatch) |=> (cnt == CNT_MIN));

  p_phase_turn_r3: assert property (@(posedge clk) disable iff (rst)
    (modeReg == MODE_PHASE && tickEn && !cntDown && atMax)
      |=> (cnt == CNT_MAX - 1'b1 && cntDown));

  p_fast_top_skip_r9: assert property (@(posedge clk) disable iff (rst)
    (modeReg == MODE_FAST && outModeReg[1] && cmpVal == CNT_MAX && !atMax)
      |-> !(stb.waveSet || stb.waveClr));
endmodule

// File: rtl/wave_timer_dp.sv
module wave_timer_dp
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  strobe_t           stb,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              cntDown,
  output logic              waveQ,
  output logic              ovfFlag,
  output logic              cmpFlag
);
  logic [CNT_W-1:0] bufReg;
  logic wrCmp, wrFlag;
  assign wrCmp  = wrEn && wrAddr == ADDR_W'(ADDR_CMP);
  assign wrFlag = wrEn && wrAddr == ADDR_W'(ADDR_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cntDown <= 1'b0;
      bufReg  <= '0;
      cmpVal  <= '0;
      waveQ   <= 1'b0;
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
      else if (stb.cntDec) cnt <= cnt - 1'b1;

      if (stb.dirToDown)    cntDown <= 1'b1;
      else if (stb.dirToUp) cntDown <= 1'b0;

      if (wrCmp) bufReg <= wrData;
      if (wrCmp && stb.cmpDirect) cmpVal <= wrData;
      else if (stb.loadCmp)       cmpVal <= bufReg;

      if (stb.waveSet)      waveQ <= 1'b1;
      else if (stb.waveClr) waveQ <= 1'b0;
      else if (stb.waveTgl) waveQ <= ~waveQ;

      if (stb.ovfSet)                 ovfFlag <= 1'b1;
      else if (wrFlag && wrData[0])   ovfFlag <= 1'b0;
      if (stb.cmpSet)                 cmpFlag <= 1'b1;
      else if (wrFlag && wrData[1])   cmpFlag <= 1'b0;
    end
  end

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(cnt));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !(wrFlag && wrData[0])) |=> ovfFlag);

  p_cmp_flag_r6: assert property (@(posedge clk) disable iff (rst)
    stb.cmpSet |=> cmpFlag);
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              pinDirEn,
  input  logic              portDataIn,
  output logic              pinOut,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              cmpFlag
);
  strobe_t          stb;
  logic [CNT_W-1:0] cmpVal;
  logic             cntDown, waveQ, pinConnect;

  wave_timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pinDirEn(pinDirEn), .cnt(count), .cmpVal(cmpVal),
    .cntDown(cntDown), .stb(stb), .pinConnect(pinConnect)
  );

  wave_timer_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .stb(stb), .cnt(count), .cmpVal(cmpVal),
    .cntDown(cntDown), .waveQ(waveQ), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  assign pinOut = pinConnect ? waveQ : portDataIn;
endmodule

// File: tb/sim_wave_timer.sv
module sim_wave_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, tickEn = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic pinDirEn = 1'b0, portDataIn = 1'b0;
  logic pinOut, ovfFlag, cmpFlag;
  logic [7:0] count;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pinDirEn(pinDirEn), .portDataIn(portDataIn),
    .pinOut(pinOut), .count(count), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  typedef struct packed {logic [7:0] cnt; logic pin; logic ovf; logic cmp;} expItem_t;
  expItem_t expQ[$];
  string    tagQ[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // independent reference model
  logic [1:0] mMode, mOm;
  logic [7:0] mCnt, mBuf, mOcr;
  logic mDown, mWave, mOvf, mCmp;

  task automatic modelReset();
    mMode = 0; mOm = 0; mCnt = 0; mBuf = 0; mOcr = 0;
    mDown = 0; mWave = 0; mOvf = 0; mCmp = 0;
  endtask

  task automatic modelStep();
    logic [7:0] nCnt, nOcr; logic nDown, nWave, ovfS, cmpS, m, atMax, atZero;
    nCnt = mCnt; nOcr = mOcr; nDown = mDown; nWave = mWave; ovfS = 0; cmpS = 0;
    m = (mCnt == mOcr); atMax = (mCnt == 8'hFF); atZero = (mCnt == 8'h00);
    if (tickEn) begin
      cmpS = m;
      case (mMode)
        2'd0, 2'd2: begin
          nCnt = (mMode == 2'd2 && m) ? 8'h00 : mCnt + 8'd1;
          ovfS = atMax;
          if (m) case (mOm) 2'd1: nWave = ~mWave; 2'd2: nWave = 0; 2'd3: nWave = 1; default: ; endcase
        end
        2'd3: begin
          nCnt = mCnt + 8'd1; ovfS = atMax;
          if (atMax) nOcr = mBuf;
          if (mOm[1]) begin
            if (m && mOcr != 8'hFF) nWave = mOm[0];
            if (atMax) nWave = ~mOm[0];
          end
        end
        default: begin
          if (mDown) begin
            if (atZero) begin nCnt = 8'd1; nDown = 0; end else nCnt = mCnt - 8'd1;
          end else begin
            if (atMax) begin nCnt = 8'hFE; nDown = 1; end else nCnt = mCnt + 8'd1;
          end
          ovfS = atZero;
          if (atMax) nOcr = mBuf;
          if (mOm[1] && m) nWave = mDown ? ~mOm[0] : mOm[0];
        end
      endcase
    end
    if (wrEn && wrAddr == 2'd1) begin
      if (mMode == 2'd0 || mMode == 2'd2) nOcr = wrData;
      mBuf = wrData;
    end
    if (ovfS) mOvf = 1; else if (wrEn && wrAddr == 2'd2 && wrData[0]) mOvf = 0;
    if (cmpS) mCmp = 1; else if (wrEn && wrAddr == 2'd2 && wrData[1]) mCmp = 0;
    if (wrEn && wrAddr == 2'd0) begin mMode = wrData[1:0]; mOm = wrData[3:2]; end
    mCnt = nCnt; mOcr = nOcr; mDown = nDown; mWave = nWave;
  endtask

  // driver: one cycle; called at posedge+1
  task automatic cyc(input logic t, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input string tag);
    logic conn; expItem_t e;
    tickEn = t; wrEn = w; wrAddr = a; wrData = d;
    conn = pinDirEn && mOm != 2'b00 && !((mMode == 2'd1 || mMode == 2'd3) && mOm == 2'b01);
    e.cnt = mCnt; e.pin = conn ? mWave : portDataIn; e.ovf = mOvf; e.cmp = mCmp;
    expQ.push_back(e); tagQ.push_back(tag);
    @(posedge clk); modelStep(); #1;
    tickEn = 0; wrEn = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(1'b0, 1'b1, a, d, tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'd0, tag);
  endtask

  task automatic runGapped(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(i % 3 != 1, 1'b0, 2'd0, 8'd0, tag);
  endtask

  task automatic doReset();
    rst = 1; tickEn = 0; wrEn = 0;
    @(posedge clk); modelReset(); #1;
    rst = 0;
  endtask

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e; string tg;
      e = expQ.pop_front(); tg = tagQ.pop_front();
      check1(tg, "count", count, e.cnt);
      check1(tg, "pinOut", pinOut, e.pin);
      check1(tg, "ovfFlag", ovfFlag, e.ovf);
      check1(tg, "cmpFlag", cmpFlag, e.cmp);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    cyc(0, 0, 0, 0, "R12 reset state");
    run(3, "R12 reset state");

    // R1 / R7 free-running, toggle, gapped ticks
    pinDirEn = 1;
    wr(2'd1, 8'h10, "R4 direct load");
    wr(2'd0, 8'b0100, "R12 ctrl write");
    runGapped(300, "R1 gapped ticks");
    run(300, "R7 toggle");
    wr(2'd2, 8'h03, "R5 R6 flag clear");
    run(20, "R5 R6 after clear");
    wr(2'd0, 8'b1000, "R7 clear on match");
    run(270, "R7 clear on match");
    wr(2'd0, 8'b1100, "R7 set on match");
    run(270, "R7 set on match");

    // R2 CTC
    doReset(); pinDirEn = 1;
    wr(2'd0, 8'b0110, "R2 ctrl");
    wr(2'd1, 8'h20, "R2 cmp");
    run(150, "R2 ctc wrap");
    wr(2'd1, 8'h05, "R4 ctc immediate");
    run(80, "R2 ctc new top");

    // R8 / R4 fast PWM
    doReset(); pinDirEn = 1;
    wr(2'd1, 8'h40, "R4 fast buffer");
    wr(2'd0, 8'b1011, "R8 ctrl");
    run(300, "R8 non-inverting");
    run(100, "R8 non-inverting");
    wr(2'd1, 8'hC0, "R4 deferred write");
    run(400, "R4 fast deferred load");
    wr(2'd0, 8'b1111, "R8 ctrl inv");
    run(300, "R8 inverting");

    // R9 compare at 0xFF
    wr(2'd1, 8'hFF, "R9 cmp FF");
    run(600, "R9 fast top match ignored");
    wr(2'd0, 8'b1011, "R9 ctrl");
    run(600, "R9 fast top non-inverting");

    // R11 pin mux
    wr(2'd0, 8'b0111, "R11 reserved field");
    portDataIn = 1; run(10, "R11 reserved passes port");
    portDataIn = 0; run(10, "R11 reserved passes port");
    wr(2'd0, 8'b1011, "R11 ctrl");
    pinDirEn = 0; portDataIn = 1; run(300, "R11 direction off");
    pinDirEn = 1; run(20, "R11 reconnect");
    wr(2'd0, 8'b0011, "R11 field zero");
    run(20, "R11 disconnected");

    // R3 / R10 / R5 phase-correct
    doReset(); pinDirEn = 1;
    wr(2'd1, 8'h80, "R4 phase buffer");
    wr(2'd0, 8'b1001, "R10 ctrl");
    run(1100, "R3 R10 phase non-inverting");
    wr(2'd1, 8'h30, "R4 phase deferred");
    run(300, "R4 phase deferred load");
    wr(2'd0, 8'b1101, "R10 ctrl inv");
    run(1100, "R10 R5 phase inverting");
    wr(2'd2, 8'h01, "R5 phase ovf clear");
    run(600, "R5 phase ovf at bottom");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule